// File: doc/BRIEF.md
# Free-Running Up-Counter Timer with Control/Status Register

This block is a free-running timer. Its counter is 16 bits wide and counts up. Software configures it through an 8-bit control/status byte and can read or load the counter directly. The count advances on ticks taken from a free-running prescaler of the system clock, and software picks the divide ratio. Software can halt counting with a stop bit, and it can zero the counter with a self-clearing clear command. When the counter wraps past its all-ones value, it raises an overflow flag. That flag drives an interrupt line, which is gated by an enable bit.

Software reaches the block over a plain synchronous register port that has no back-pressure. A write is taken on every clock edge where the write enable is high. Read data is combinational from the address, and a read never stalls. A read can be tagged as part of a read-modify-write sequence. On such a read the overflow flag reads as one, so the write-back that follows cannot wipe out a pending flag. A single input, `capture_busy`, blocks any change to the prescaler select while a capture unit elsewhere depends on the timer's rate.

Register map (bus address `bus_addr`): 0 is the control byte, returned in `bus_rdata[7:0]` with the upper bits zero. 1 is the counter. Control byte fields: bit 7 overflow flag, bit 6 interrupt enable, bit 5 stop, bit 4 reserved, bit 3 clear command, bits 2:0 count-rate select.

Top module: `frt_timer`

## Requirements
- R1: After reset the counter reads 0000h, the control byte reads 00h and `irq` is low.
- R2: While the stop bit (bit 5) is 0, the counter increases by exactly one every 2^(sel+1) clock cycles, where sel is control bits 2:0 (divide-by-2 for sel=0 through divide-by-256 for sel=7).
- R3: While the stop bit is 1, the counter holds its value.
- R4: When a count tick moves the counter from FFFFh to 0000h, the overflow flag (bit 7) becomes 1.
- R5: Writing the control byte with bit 7 = 0 clears the overflow flag. Writing it with bit 7 = 1 leaves the flag unchanged, so a flag at 0 stays 0.
- R6: A control read with `bus_rmw` high returns bit 7 as 1, whatever the flag's value. With `bus_rmw` low it returns the flag itself.
- R7: `irq` is high exactly when both the overflow flag and the interrupt enable (bit 6) are 1.
- R8: Writing the control byte with bit 3 = 1 sets the counter to 0000h on that edge, whether the timer is running or stopped. Bit 3 always reads 0.
- R9: A write to address 1 loads the counter with `bus_wdata`. This load takes priority over a count tick on the same edge.
- R10: If a wrap and a control write with bit 7 = 0 land on the same edge, the overflow flag ends up 1.
- R11: While `capture_busy` is high, control writes leave the select field unchanged and still update the other fields. While it is low, the select field is written normally.
- R12: Reserved bit 4 always reads 0, even after a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control byte, 1 counter |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 16 | Write data (control uses bits 7:0) |
| bus_rmw | input | 1 | Marks the current read as part of a read-modify-write |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| capture_busy | input | 1 | Blocks changes to the count-rate select |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest cases to reach are collisions with a count tick on the same edge. One is a counter load against an increment. The other is a software flag clear against a wrap. Both are hard because the prescaler phase cannot be seen from the ports. The stimulus finds the phase first. At the fastest rate it starts the timer from a known value and reads the counter after every edge until the value moves, which marks a tick edge; ticks then follow on every second edge. It then schedules the load, or the preload of FFFFh followed by the clearing control write, so that the write lands on the next tick edge.

// File: rtl/frt_pkg.sv
package frt_pkg;

  localparam int unsigned CTRL_W = 8;

  // bus addresses
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  // control byte bit positions (software-visible layout)
  localparam int unsigned B_OVF  = 7;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_STOP = 5;
  localparam int unsigned B_RSV  = 4;
  localparam int unsigned B_CLR  = 3;
  localparam int unsigned SEL_LO = 0;

  // decoded fields of a control write
  typedef struct packed {
    logic       keep_ovf;
    logic       ie;
    logic       stop;
    logic       clr;
    logic [2:0] sel;
  } ctrl_wr_t;

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // tap i fires once every 2^(i+1) cycles: low i+1 bits all ones
  for (genvar i = 0; i < PRE_W; i++) begin : g_tap
    assign taps[i] = &pre_q[i:0];
  end

  assign tick = taps[sel];
endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl
  import frt_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  ctrl_wr_t         wr_fields,
  input  logic             ovf_evt,
  input  logic             cap_busy,
  output logic             ovf_q,
  output logic             ie_q,
  output logic             stop_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             clr_pulse
);
  // overflow flag: hardware set beats software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ovf_q <= 1'b0;
    else if (ovf_evt)                      ovf_q <= 1'b1;
    else if (wr_ctrl && !wr_fields.keep_ovf) ovf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q   <= wr_fields.ie;
      stop_q <= wr_fields.stop;
    end
  end

  // rate select frozen while capture logic relies on it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sel_q <= '0;
    else if (wr_ctrl && !cap_busy) sel_q <= wr_fields.sel[SEL_W-1:0];
  end

  assign clr_pulse = wr_ctrl && wr_fields.clr;
endmodule

// File: rtl/frt_count.sv
module frt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // wrap only counts when the increment actually happens
  assign ovf_evt = step && !clr && !ld && (cnt_q == CNT_MAX);
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             bus_rmw,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             capture_busy,
  output logic             irq
);
  logic             wr_ctrl, wr_cnt;
  ctrl_wr_t         wr_fields;
  logic             ovf_q, ie_q, stop_q, clr_pulse;
  logic [SEL_W-1:0] sel_q;
  logic             tick, step, ovf_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [CTRL_W-1:0] ctrl_byte;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_cnt  = bus_we && (bus_addr == ADDR_CNT);

  always_comb begin
    wr_fields          = '0;
    wr_fields.keep_ovf = bus_wdata[B_OVF];
    wr_fields.ie       = bus_wdata[B_IE];
    wr_fields.stop     = bus_wdata[B_STOP];
    wr_fields.clr      = bus_wdata[B_CLR];
    wr_fields.sel      = bus_wdata[SEL_LO +: 3];
  end

  frt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel_q),
    .tick (tick)
  );

  frt_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_fields(wr_fields),
    .ovf_evt  (ovf_evt),
    .cap_busy (capture_busy),
    .ovf_q    (ovf_q),
    .ie_q     (ie_q),
    .stop_q   (stop_q),
    .sel_q    (sel_q),
    .clr_pulse(clr_pulse)
  );

  assign step = tick && !stop_q;

  frt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_pulse),
    .ld     (wr_cnt),
    .ld_val (bus_wdata),
    .step   (step),
    .cnt_q  (cnt_q),
    .ovf_evt(ovf_evt)
  );

  // read view: rmw reads force the flag to one, clear and reserved read zero
  always_comb begin
    ctrl_byte                    = '0;
    ctrl_byte[B_OVF]             = ovf_q || bus_rmw;
    ctrl_byte[B_IE]              = ie_q;
    ctrl_byte[B_STOP]            = stop_q;
    ctrl_byte[SEL_LO +: SEL_W]   = sel_q;
  end

  always_comb begin
    if (bus_addr == ADDR_CNT) bus_rdata = cnt_q;
    else                      bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_byte};
  end

  assign irq = ovf_q && ie_q;
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_addr,
  input logic             bus_we,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] bus_rdata,
  input logic             capture_busy,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q,
  input logic             stop_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             tick
);
  logic ctl_wr, cnt_wr;
  assign ctl_wr = bus_we && !bus_addr;
  assign cnt_wr = bus_we && bus_addr;

  // R3: a stopped counter with no bus write keeps its value
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !bus_we) |=> $stable(cnt_q));

  // R4: a tick at all-ones with the timer running raises the flag
  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_q && (&cnt_q) && !bus_we) |=> ovf_q);

  // R5: writing a one never drops a set flag
  p_one_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[7] && ovf_q) |=> ovf_q);

  // R7: disabling the interrupt takes irq low on the next cycle
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[6]) |=> !irq);

  // R8: clear command zeroes the counter
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[3]) |=> (cnt_q == '0));

  // R9: counter load wins over any tick
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(bus_wdata)));

  // R11: rate select frozen under capture activity
  p_sel_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && capture_busy) |=> $stable(sel_q));

  // R8, R12: clear and reserved bits read zero
  always_comb begin
    if (rst_n && !bus_addr) begin
      a_ctrl_zero_bits_r12: assert (bus_rdata[4] == 1'b0 && bus_rdata[3] == 1'b0);
    end
  end
endmodule

bind frt_timer frt_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .capture_busy(capture_busy),
  .irq         (irq),
  .cnt_q       (cnt_q),
  .ovf_q       (ovf_q),
  .stop_q      (stop_q),
  .sel_q       (sel_q),
  .tick        (tick)
);

// File: tb/frt_timer_tb.sv
module frt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rmw = 1'b0;
  logic [15:0] bus_rdata;
  logic        capture_busy = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic A_CTL = 1'b0;
  localparam logic A_CNT = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  frt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
    .capture_busy(capture_busy), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    rd(A_CTL, v); chk("R1 ctrl", v, 16'h0000);
    rd(A_CNT, v); chk("R1 cnt", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_rates();
    logic [15:0] v;
    int sels[4] = '{0, 1, 3, 7};
    foreach (sels[i]) begin
      int div = 1 << (sels[i] + 1);
      wr(A_CTL, 16'h0020 | 16'(sels[i]));
      wr(A_CNT, 16'h0000);
      wr(A_CTL, 16'(sels[i]));
      idle(8 * div);
      rd(A_CNT, v); chk($sformatf("R2 rate sel=%0d", sels[i]), v, 16'd8);
    end
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(A_CTL, 16'h0020);
    wr(A_CNT, 16'h4321);
    idle(600);
    rd(A_CNT, v); chk("R3 hold", v, 16'h4321);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(A_CNT, 16'h5555);
    wr(A_CTL, 16'h0028);
    rd(A_CNT, v); chk("R8 clear stopped", v, 16'h0000);
    rd(A_CTL, v); chk("R8 clr reads 0", v, 16'h0020);
    wr(A_CNT, 16'h7777);
    wr(A_CTL, 16'h000F);
    rd(A_CNT, v); chk("R8 clear running", v, 16'h0000);
  endtask

  task automatic t_flag();
    logic [15:0] v;
    wr(A_CTL, 16'h0000);
    wr(A_CNT, 16'hFFFF);
    idle(3);
    rd(A_CTL, v); chk("R4 wrap sets flag", v, 16'h0080);
    chk("R7 irq off when disabled", {15'd0, irq}, 16'd0);
    wr(A_CTL, 16'h00A0);
    rd(A_CTL, v); chk("R5 one keeps flag", v, 16'h00A0);
    wr(A_CTL, 16'h00E0);
    chk("R7 irq on", {15'd0, irq}, 16'd1);
    wr(A_CTL, 16'h00A0);
    chk("R7 irq masked", {15'd0, irq}, 16'd0);
    wr(A_CTL, 16'h0060);
    rd(A_CTL, v); chk("R5 zero clears flag", v, 16'h0060);
    chk("R7 irq off with flag clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_rmw();
    logic [15:0] v;
    wr(A_CTL, 16'h0020);
    bus_rmw = 1'b1;
    rd(A_CTL, v); chk("R6 rmw read", v, 16'h00A0);
    bus_rmw = 1'b0;
    rd(A_CTL, v); chk("R6 plain read", v, 16'h0020);
    wr(A_CTL, 16'h00A0);
    rd(A_CTL, v); chk("R5 one does not set", v, 16'h0020);
  endtask

  task automatic t_sel_lock();
    logic [15:0] v;
    wr(A_CTL, 16'h0022);
    capture_busy = 1'b1;
    wr(A_CTL, 16'h0065);
    rd(A_CTL, v); chk("R11 sel locked", v, 16'h0062);
    capture_busy = 1'b0;
    wr(A_CTL, 16'h0025);
    rd(A_CTL, v); chk("R11 sel free", v, 16'h0025);
  endtask

  task automatic t_rsv();
    logic [15:0] v;
    wr(A_CTL, 16'h0030);
    rd(A_CTL, v); chk("R12 reserved reads 0", v, 16'h0020);
  endtask

  // leaves the bench just after a tick edge, running at divide-by-2
  task automatic find_tick();
    logic [15:0] v;
    wr(A_CTL, 16'h0020);
    wr(A_CNT, 16'h0100);
    wr(A_CTL, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      rd(A_CNT, v);
      if (v != 16'h0100) break;
      @(negedge clk);
    end
  endtask

  task automatic t_load_vs_tick();
    logic [15:0] v;
    find_tick();
    idle(1);
    wr(A_CNT, 16'h1234);
    rd(A_CNT, v); chk("R9 load beats tick", v, 16'h1234);
    idle(1);
    rd(A_CNT, v); chk("R9 hold after load", v, 16'h1234);
    idle(1);
    rd(A_CNT, v); chk("R2 resumes after load", v, 16'h1235);
  endtask

  task automatic t_ovf_vs_clear();
    logic [15:0] v;
    find_tick();
    wr(A_CNT, 16'hFFFF);
    wr(A_CTL, 16'h0000);
    rd(A_CTL, v); chk("R10 set beats clear", v, 16'h0080);
    rd(A_CNT, v); chk("R10 counter wrapped", v, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_rates();
    t_stop();
    t_clear();
    t_flag();
    t_rmw();
    t_sel_lock();
    t_rsv();
    t_load_vs_tick();
    t_ovf_vs_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule